// File: doc/BRIEF.md
# Integration Window Timer

This block sets the timing of the integration windows for a bank of charge-integrating converters. A fixed 80 MHz tick (12.5 ns) drives it. Software programs a 28-bit period code N, and each window then lasts N+1 ticks. Three commands steer it: a continuous start that repeats windows back to back, a single shot that runs one window, and a stop. At the last tick of every window it raises a one-cycle strobe. That strobe marks the point where the integrator halves swap and readout may begin. A run flag stays high for as long as any window is in progress.

A period write is checked against a legal window. Codes from 13279 (about 166 us) up to 79999999 (1 s) are accepted, and any other code is dropped so that the last accepted code stays in force. An accepted code is held as pending. It becomes the active period only when a window starts, so a window in flight never changes length. A stop that arrives mid-window does not cut the window short: the window completes, issues its end strobe, and the block then goes idle. Serial clocking of the converters, data capture and the analog side are handled elsewhere.

Top module: `intwin_timer`

## Requirements
- R1: After reset, `running` and `winEnd` are 0, and the pending period code equals the parameter RESET_N. A run started with no write made since reset therefore ends its first window RESET_N+1 cycles after the start edge.
- R2: A window lasts N+1 clock cycles, where N is the active period code. After a start or single command is taken at clock edge E0, the first `winEnd` is high in the cycle that follows edge E0+N.
- R3: `winEnd` is high for exactly one cycle per window, and only while `running` is high.
- R4: In continuous mode, windows follow each other with no gap. `winEnd` recurs every N+1 cycles until a stop ends the run.
- R5: A single-shot command runs exactly one window. `running` is still high in the `winEnd` cycle and is low in the cycle after it.
- R6: A period write with `periodIn` inside [MIN_N, MAX_N] (both ends included) replaces the pending code. A write outside that range has no effect, and the previously accepted code stays pending.
- R7: A stop issued during a continuous run lets the current window finish with its `winEnd`, and the block is idle in the cycle after that strobe. This also holds when the stop falls in the `winEnd` cycle itself. A stop issued while idle has no effect on the next run.
- R8: The active period is loaded from the pending code only when a window starts. A write made mid-window applies from the next window. A write in a `winEnd` cycle applies from the window after the next one.
- R9: A start or single command that arrives while `running` is high is ignored. This includes the `winEnd` cycle of a single shot, and it means a continuous run never becomes a single shot or the reverse.
- R10: When commands coincide while the block is idle, stop takes precedence over start, and start takes precedence over single.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 80 MHz tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodWr | input | 1 | Write strobe for the period code |
| periodIn | input | CNT_W (28) | Period code N (window length in ticks minus one) |
| cmdStart | input | 1 | Start continuous acquisition |
| cmdSingle | input | 1 | Trigger one measurement window |
| cmdStop | input | 1 | Stop acquisition at the end of the current window |
| winEnd | output | 1 | One-cycle strobe in the last tick of each window |
| running | output | 1 | High while a window is in progress |

## Verification
Two events can land on the same tick as a window boundary: a period write, and a stop or a redundant start/single command. The bench drives each of these in the exact cycle in which `winEnd` is high. It then measures the lengths of the following windows, or the level of `running` one cycle later. Each measurement is compared with the length worked out from the code that was pending before that edge. The same commands are also driven mid-window and while idle, and the results in those cycles are compared with the results at the boundary.

// File: rtl/intwin_pkg.sv
package intwin_pkg;
  // Run mode held by the control FSM
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CONT = 2'd1,
    MODE_ONE  = 2'd2
  } runMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWin;  // restart counter and take pending period as active
    logic countEn;  // a window is in progress
  } winCtl_t;
endpackage

// File: rtl/intwin_dpath.sv
module intwin_dpath
  import intwin_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int MIN_N   = 13279,
  parameter int MAX_N   = 79999999,
  parameter int RESET_N = 13279
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodWr,
  input  logic [CNT_W-1:0] periodIn,
  input  winCtl_t          ctl,
  output logic             winDone
);
  localparam logic [CNT_W-1:0] LO_CODE  = CNT_W'(MIN_N);
  localparam logic [CNT_W-1:0] HI_CODE  = CNT_W'(MAX_N);
  localparam logic [CNT_W-1:0] RST_CODE = CNT_W'(RESET_N);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] pendN;
  logic [CNT_W-1:0] actN;
  logic [CNT_W-1:0] tickCnt;
  logic             codeOk;

  always_comb begin
    codeOk  = (periodIn >= LO_CODE) && (periodIn <= HI_CODE);
    winDone = ctl.countEn && (tickCnt == actN);
  end

  // Pending period: accepted codes only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendN <= RST_CODE;
    end else if (periodWr && codeOk) begin
      pendN <= periodIn;
    end
  end

  // Active period and tick counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actN    <= RST_CODE;
      tickCnt <= '0;
    end else if (ctl.loadWin) begin
      actN    <= pendN;
      tickCnt <= '0;
    end else if (ctl.countEn && !winDone) begin
      tickCnt <= tickCnt + ONE;
    end
  end
endmodule

// File: rtl/intwin_ctrl.sv
module intwin_ctrl
  import intwin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  logic    cmdSingle,
  input  logic    cmdStop,
  input  logic    winDone,
  output winCtl_t ctl,
  output logic    running
);
  runMode_e mode, modeNext;
  logic     stopPend;
  logic     isIdle, launchCont, launchOne, keepGoing;

  always_comb begin
    isIdle     = (mode == MODE_IDLE);
    // Idle priority: stop > start > single
    launchCont = isIdle && cmdStart && !cmdStop;
    launchOne  = isIdle && cmdSingle && !cmdStart && !cmdStop;
    keepGoing  = (mode == MODE_CONT) && !stopPend && !cmdStop;

    ctl.loadWin = launchCont || launchOne || (winDone && keepGoing);
    ctl.countEn = !isIdle;
    running     = !isIdle;

    modeNext = mode;
    unique case (mode)
      MODE_IDLE: begin
        if (launchCont)     modeNext = MODE_CONT;
        else if (launchOne) modeNext = MODE_ONE;
      end
      MODE_CONT: if (winDone && !keepGoing) modeNext = MODE_IDLE;
      MODE_ONE:  if (winDone)               modeNext = MODE_IDLE;
      default:                              modeNext = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      stopPend <= 1'b0;
    end else begin
      mode     <= modeNext;
      stopPend <= (mode == MODE_CONT) && !winDone && (stopPend || cmdStop);
    end
  end
endmodule

// File: rtl/intwin_timer.sv
module intwin_timer
  import intwin_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int MIN_N   = 13279,
  parameter int MAX_N   = 79999999,
  parameter int RESET_N = 13279
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodWr,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             cmdStart,
  input  logic             cmdSingle,
  input  logic             cmdStop,
  output logic             winEnd,
  output logic             running
);
  winCtl_t ctl;
  logic    winDone;

  intwin_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .cmdSingle (cmdSingle),
    .cmdStop   (cmdStop),
    .winDone   (winDone),
    .ctl       (ctl),
    .running   (running)
  );

  intwin_dpath #(
    .CNT_W   (CNT_W),
    .MIN_N   (MIN_N),
    .MAX_N   (MAX_N),
    .RESET_N (RESET_N)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .periodWr (periodWr),
    .periodIn (periodIn),
    .ctl      (ctl),
    .winDone  (winDone)
  );

  assign winEnd = winDone;
endmodule

// File: rtl/intwin_timer_chk.sv
module intwin_timer_chk #(
  parameter int MIN_N = 13279,
  parameter int MAX_N = 79999999
) (
  input logic clk,
  input logic rstN,
  input logic cmdStart,
  input logic cmdSingle,
  input logic cmdStop,
  input logic winEnd,
  input logic running
);
  // Cycles elapsed inside the current window
  logic [31:0] gap;
  always_ff @(posedge clk) begin
    if (!rstN || winEnd || !running) gap <= '0;
    else                             gap <= gap + 32'd1;
  end

  p_end_in_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |-> running);

  p_end_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |=> !winEnd);

  p_win_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |-> (gap >= 32'(MIN_N) && gap <= 32'(MAX_N)));

  p_no_cut_r7: assert property (@(posedge clk) disable iff (!rstN)
    (running && !winEnd) |=> running);

  p_single_go_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && cmdSingle && !cmdStart && !cmdStop) |=> running);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cmdStart && !cmdSingle) |=> !running);
endmodule

bind intwin_timer intwin_timer_chk #(.MIN_N(MIN_N), .MAX_N(MAX_N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdStart  (cmdStart),
  .cmdSingle (cmdSingle),
  .cmdStop   (cmdStop),
  .winEnd    (winEnd),
  .running   (running)
);

// File: tb/intwin_timer_bench.sv
`timescale 1ns/1ps
module intwin_timer_bench;
  localparam int CNT_W   = 28;
  localparam int MIN_N   = 3;
  localparam int MAX_N   = 12;
  localparam int RESET_N = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             periodWr;
  logic [CNT_W-1:0] periodIn;
  logic             cmdStart, cmdSingle, cmdStop;
  logic             winEnd, running;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  intwin_timer #(
    .CNT_W(CNT_W), .MIN_N(MIN_N), .MAX_N(MAX_N), .RESET_N(RESET_N)
  ) u_intwin_timer (
    .clk(clk), .rstN(rstN), .periodWr(periodWr), .periodIn(periodIn),
    .cmdStart(cmdStart), .cmdSingle(cmdSingle), .cmdStop(cmdStop),
    .winEnd(winEnd), .running(running)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive commands for one edge; returns at the next falling edge
  task automatic cmd(input bit s, input bit g, input bit p);
    cmdStart = s; cmdSingle = g; cmdStop = p;
    @(posedge clk);
    @(negedge clk);
    cmdStart = 1'b0; cmdSingle = 1'b0; cmdStop = 1'b0;
  endtask

  task automatic wrPeriod(input int v);
    periodIn = CNT_W'(v);
    periodWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    periodWr = 1'b0;
  endtask

  // Count falling edges until winEnd, starting at window cycle c0
  task automatic waitEnd(input int c0, output int c);
    c = c0;
    while (!winEnd && c < 100) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #200000;
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int c;
    rstN = 1'b0; periodWr = 1'b0; periodIn = '0;
    cmdStart = 1'b0; cmdSingle = 1'b0; cmdStop = 1'b0;
    repeat (3) @(negedge clk);
    chk(!running && !winEnd, "R1 reset outputs", int'(running), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: default period applies
    cmd(0, 1, 0);
    waitEnd(1, c);
    chk(c == RESET_N + 1, "R1 default window", c, RESET_N + 1);
    @(negedge clk);

    // R2/R5/R6: sweep every legal code with single shots
    for (int n = MIN_N; n <= MAX_N; n++) begin
      wrPeriod(n);
      cmd(0, 1, 0);
      waitEnd(1, c);
      chk(c == n + 1, "R2 window length", c, n + 1);
      chk(running == 1'b1, "R5 running in end cycle", int'(running), 1);
      @(negedge clk);
      chk(!running && !winEnd, "R5 idle after single", int'(running), 0);
      repeat (3) @(negedge clk);
      chk(!running && !winEnd, "R3 quiet while idle", int'(winEnd), 0);
    end

    // R6: illegal codes ignored, last legal (MAX_N) kept
    begin
      int bad[4] = '{MIN_N - 1, MAX_N + 1, 0, 268435455};
      foreach (bad[i]) begin
        wrPeriod(bad[i]);
        cmd(0, 1, 0);
        waitEnd(1, c);
        chk(c == MAX_N + 1, "R6 illegal code ignored", c, MAX_N + 1);
        @(negedge clk);
      end
    end

    // R4/R3: continuous windows of 5
    wrPeriod(4);
    cmd(1, 0, 0);
    waitEnd(1, c);
    chk(c == 5, "R4 first continuous window", c, 5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!winEnd && running, "R3 strobe one cycle", int'(winEnd), 0);
      waitEnd(1, c);
      chk(c == 5, "R4 back to back window", c, 5);
    end

    // R7: stop mid-window completes the window
    @(negedge clk);
    cmd(0, 0, 1);
    waitEnd(2, c);
    chk(c == 5, "R7 stop lets window finish", c, 5);
    @(negedge clk);
    chk(!running, "R7 idle after stopped window", int'(running), 0);

    // R7: stop in the boundary cycle
    cmd(1, 0, 0);
    waitEnd(1, c);
    chk(c == 5, "R7 window before boundary stop", c, 5);
    cmd(0, 0, 1);
    chk(!running && !winEnd, "R7 boundary stop idles", int'(running), 0);

    // R7: stop while idle has no lasting effect
    cmd(0, 0, 1);
    chk(!running, "R7 idle stop", int'(running), 0);
    cmd(1, 0, 0);
    waitEnd(1, c);
    chk(c == 5, "R7 run after idle stop", c, 5);
    @(negedge clk);
    chk(running == 1'b1, "R7 idle stop not remembered", int'(running), 1);
    waitEnd(1, c);
    cmd(0, 0, 1);
    chk(!running, "R7 stop at boundary", int'(running), 0);

    // R8: period writes at boundary and mid-window
    cmd(1, 0, 0);
    waitEnd(1, c);
    chk(c == 5, "R8 window before writes", c, 5);
    wrPeriod(8);
    waitEnd(1, c);
    chk(c == 5, "R8 boundary write deferred", c, 5);
    @(negedge clk);
    waitEnd(1, c);
    chk(c == 9, "R8 boundary write applied", c, 9);
    @(negedge clk);
    wrPeriod(6);
    waitEnd(2, c);
    chk(c == 9, "R8 mid write not current", c, 9);
    @(negedge clk);
    waitEnd(1, c);
    chk(c == 7, "R8 mid write next window", c, 7);
    cmd(0, 0, 1);
    chk(!running, "R8 stopped", int'(running), 0);

    // R9: commands while running are ignored
    wrPeriod(5);
    cmd(0, 1, 0);
    cmd(1, 0, 0);
    cmd(0, 1, 0);
    waitEnd(3, c);
    chk(c == 6, "R9 single unaffected", c, 6);
    cmd(1, 0, 0);
    chk(!running, "R9 start in single end cycle ignored", int'(running), 0);
    cmd(1, 0, 0);
    cmd(0, 1, 0);
    waitEnd(2, c);
    chk(c == 6, "R9 continuous window", c, 6);
    @(negedge clk);
    chk(running == 1'b1, "R9 continuous kept", int'(running), 1);
    cmd(0, 0, 1);
    waitEnd(2, c);
    @(negedge clk);
    chk(!running, "R9 stopped", int'(running), 0);

    // R10: idle priority
    cmd(1, 0, 1);
    chk(!running, "R10 stop over start", int'(running), 0);
    cmd(0, 1, 1);
    chk(!running, "R10 stop over single", int'(running), 0);
    cmd(1, 1, 0);
    waitEnd(1, c);
    chk(c == 6, "R10 start over single window", c, 6);
    @(negedge clk);
    chk(running == 1'b1, "R10 start chose continuous", int'(running), 1);
    waitEnd(1, c);
    cmd(0, 0, 1);
    chk(!running, "R10 final stop", int'(running), 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule